// File: doc/BRIEF.md
# Register Override Array Sequencer

The sequencer walks a list of 32-bit override words held in a word-addressed memory. It reads the words through a synchronous read port that returns data one cycle after the request. Every non-zero word in the list is an array header. The header names one of four write modes, a start address and an element count. The data words that follow the header are split into elements, and each element is issued as one write on one of three ports: a 32-bit register write port, a byte-wide analog-domain register bus port with two selectable bus instances, or a byte write port into a small parameter RAM. After the last element of an array, any unused lanes of the final data word are skipped, so the next header always starts on a word boundary. The list ends at an all-zero word.

The sequencer is used in two steps. A `start` pulse loads the list base address and arms the block. A later `trigger` pulse starts the walk. A stop or abort request that arrives while the block is armed cancels the run, and no reads or writes take place. Once the walk has begun, a stop request has no effect. An abort request ends the walk on the next edge. Every run finishes with a one-cycle `done` pulse and a 2-bit status.

States: `S_IDLE` waits for `start`. `S_ARMED` waits for the trigger. `S_HDR_RD` and `S_HDR` fetch and decode a header. `S_DAT_RD` and `S_DAT` fetch a data word. `S_WR` issues elements. `S_DONE` raises `done`.

Transitions:
- idle to armed on `start`.
- armed to done on stop or abort. This takes priority over a trigger in the same cycle.
- armed to header-read on `trigger`.
- header to done on a terminator word or a bad length.
- header to data-read for a valid header.
- data to write.
- write to data-read when the word's lanes are used up.
- write to header-read after the last element.
- any walking state to done on abort.
- done to idle.

Top module: `ovr_array_seq`

## Requirements
- R1: After reset, `done`, `rd_en` and all three write valids are low.
- R2: The header layout is type in bits 31:30, length in bits 29:16 and start address in bits 7:0. A word of all zeros ends the list, and `done` is then raised with status OK (0).
- R3: Type 0 issues one register write per 16-bit halfword, taking the low halfword of each data word first. The written data is zero-extended to 32 bits. The address is REG_BASE + 4*start + 4*k for element k.
- R4: For type 0 with an odd length, the upper halfword of the final data word is skipped, and the next header is read from the following word.
- R5: Type 1 issues one register write per data word with the full 32-bit value. It uses the same address rule as type 0.
- R6: Type 2 issues one bus write per byte, taking the low byte of each data word first. `bus_wr_sel` equals start bit 7 and `bus_wr_half` equals start bit 6. The 6-bit bus address begins at start bits 5:0, steps by 1 when half is set and by 2 otherwise, and wraps modulo 64.
- R7: Type 3 issues one parameter write per byte, taking the low byte first. The index is start/4 + k, modulo 2^PRM_AW.
- R8: For types 2 and 3, unused bytes of the final data word are skipped, and the next header is read from the following word.
- R9: A header whose length is 0 or above MAX_LEN ends the run with status PARAM_ERR (1). No write is issued for that header.
- R10: A stop or abort request while the block is armed ends the run with status ABORTED (2). No read or write is made. This applies even when a trigger arrives in the same cycle.
- R11: A stop request after the trigger is ignored, and the list runs to its terminator with status OK.
- R12: An abort request after the trigger raises `done` with status ABORTED on the next cycle. No write valid is raised after that. A write whose ready coincides with the abort still counts as transferred.
- R13: At most one write valid is high at a time. A valid that is not accepted stays high with its address and data unchanged, unless an abort intervenes.
- R14: `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Arm pulse; loads list_base |
| list_base | input | LIST_AW | Word address of the first list entry |
| trigger | input | 1 | Start-of-walk pulse |
| stop_req | input | 1 | Stop request |
| abort_req | input | 1 | Abort request |
| rd_en | output | 1 | List memory read request |
| rd_addr | output | LIST_AW | List memory word address |
| rd_data | input | 32 | Read data, valid one cycle after rd_en |
| reg_wr_valid | output | 1 | Register write valid |
| reg_wr_ready | input | 1 | Register write ready |
| reg_wr_addr | output | 32 | Register byte address |
| reg_wr_data | output | 32 | Register write data |
| bus_wr_valid | output | 1 | Analog bus write valid |
| bus_wr_ready | input | 1 | Analog bus write ready |
| bus_wr_sel | output | 1 | Analog bus instance select |
| bus_wr_half | output | 1 | Half-byte write size |
| bus_wr_addr | output | 6 | Analog bus register address |
| bus_wr_data | output | 8 | Analog bus write byte |
| prm_wr_valid | output | 1 | Parameter RAM write valid |
| prm_wr_ready | input | 1 | Parameter RAM write ready |
| prm_wr_idx | output | PRM_AW | Parameter RAM byte index |
| prm_wr_data | output | 8 | Parameter RAM write byte |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 OK, 1 PARAM_ERR, 2 ABORTED |

## Verification
The risky coincidence is an abort that lands on the same edge at which a write port accepts an element. The bench waits until a register write shows valid and ready together, and only then raises the abort, so both reach the design on the same edge. The scoreboard must count that element as delivered. One cycle later the bench expects `done` with ABORTED and no further valids. A second coincidence, stop together with trigger while armed, is expected to end the run with no list reads at all.

// File: rtl/ovr_pkg.sv
package ovr_pkg;

    localparam int HDR_LEN_W = 14;

    typedef enum logic [1:0] {
        AT_HALF = 2'd0,
        AT_WORD = 2'd1,
        AT_BUS  = 2'd2,
        AT_PRM  = 2'd3
    } arr_type_e;

    typedef enum logic [1:0] {
        ST_OK        = 2'd0,
        ST_PARAM_ERR = 2'd1,
        ST_ABORTED   = 2'd2
    } seq_status_e;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_ARMED  = 3'd1,
        S_HDR_RD = 3'd2,
        S_HDR    = 3'd3,
        S_DAT_RD = 3'd4,
        S_DAT    = 3'd5,
        S_WR     = 3'd6,
        S_DONE   = 3'd7
    } seq_state_e;

    typedef struct packed {
        arr_type_e            atype;
        logic [HDR_LEN_W-1:0] len;
        logic [7:0]           start;
    } arr_hdr_t;

    // last lane index used within one data word for each array type
    function automatic logic [1:0] last_lane(arr_type_e t);
        unique case (t)
            AT_HALF: return 2'd1;
            AT_WORD: return 2'd0;
            default: return 2'd3;
        endcase
    endfunction

endpackage

// File: rtl/ovr_hdr_decode.sv
module ovr_hdr_decode
    import ovr_pkg::*;
#(
    parameter int MAX_LEN = 255
) (
    input  logic [31:0] word,
    output arr_hdr_t    hdr,
    output logic        is_term,
    output logic        len_bad
);
    localparam logic [HDR_LEN_W-1:0] MAX_L = HDR_LEN_W'(MAX_LEN);

    always_comb begin
        hdr.atype = arr_type_e'(word[31:30]);
        hdr.len   = word[29:16];
        hdr.start = word[7:0];
        is_term   = (word == 32'd0);
        len_bad   = (hdr.len == '0) || (hdr.len > MAX_L);
    end
endmodule

// File: rtl/ovr_addr_gen.sv
module ovr_addr_gen
    import ovr_pkg::*;
#(
    parameter logic [31:0] REG_BASE = 32'h4004_0000,
    parameter int          PRM_AW   = 6
) (
    input  arr_hdr_t             hdr,
    input  logic [HDR_LEN_W-1:0] elem,
    output logic [31:0]          reg_addr,
    output logic [5:0]           bus_addr,
    output logic [PRM_AW-1:0]    prm_idx
);
    localparam int SUM_W = HDR_LEN_W + 1;

    logic [SUM_W-1:0] prm_sum;

    always_comb begin
        reg_addr = REG_BASE + {22'd0, hdr.start, 2'b00} + {16'd0, elem, 2'b00};
        bus_addr = hdr.start[5:0] + (hdr.start[6] ? elem[5:0] : {elem[4:0], 1'b0});
        prm_sum  = {{(SUM_W-6){1'b0}}, hdr.start[7:2]} + {1'b0, elem};
    end

    generate
        if (PRM_AW <= SUM_W) begin : g_trunc
            assign prm_idx = prm_sum[PRM_AW-1:0];
        end else begin : g_ext
            assign prm_idx = {{(PRM_AW-SUM_W){1'b0}}, prm_sum};
        end
    endgenerate
endmodule

// File: rtl/ovr_lane_pick.sv
module ovr_lane_pick (
    input  logic [31:0] dbuf,
    input  logic [1:0]  lane,
    output logic [15:0] half_v,
    output logic [7:0]  byte_v
);
    always_comb begin
        half_v = lane[0] ? dbuf[31:16] : dbuf[15:0];
        unique case (lane)
            2'd0: byte_v = dbuf[7:0];
            2'd1: byte_v = dbuf[15:8];
            2'd2: byte_v = dbuf[23:16];
            default: byte_v = dbuf[31:24];
        endcase
    end
endmodule

// File: rtl/ovr_array_seq.sv
module ovr_array_seq
    import ovr_pkg::*;
#(
    parameter int          LIST_AW  = 8,
    parameter int          MAX_LEN  = 255,
    parameter int          PRM_AW   = 6,
    parameter logic [31:0] REG_BASE = 32'h4004_0000
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [LIST_AW-1:0] list_base,
    input  logic               trigger,
    input  logic               stop_req,
    input  logic               abort_req,
    output logic               rd_en,
    output logic [LIST_AW-1:0] rd_addr,
    input  logic [31:0]        rd_data,
    output logic               reg_wr_valid,
    input  logic               reg_wr_ready,
    output logic [31:0]        reg_wr_addr,
    output logic [31:0]        reg_wr_data,
    output logic               bus_wr_valid,
    input  logic               bus_wr_ready,
    output logic               bus_wr_sel,
    output logic               bus_wr_half,
    output logic [5:0]         bus_wr_addr,
    output logic [7:0]         bus_wr_data,
    output logic               prm_wr_valid,
    input  logic               prm_wr_ready,
    output logic [PRM_AW-1:0]  prm_wr_idx,
    output logic [7:0]         prm_wr_data,
    output logic               done,
    output logic [1:0]         status
);
    seq_state_e           state, state_nx;
    logic [LIST_AW-1:0]   ptr;
    arr_hdr_t             hdr_q;
    logic [31:0]          dbuf;
    logic [HDR_LEN_W-1:0] elem;
    logic [1:0]           lane;
    seq_status_e          stat_q, stat_nx;

    arr_hdr_t             dec_hdr;
    logic                 dec_term, dec_bad;
    logic [31:0]          gen_reg_addr;
    logic [5:0]           gen_bus_addr;
    logic [PRM_AW-1:0]    gen_prm_idx;
    logic [15:0]          pick_half;
    logic [7:0]           pick_byte;
    logic                 sel_ready, fire, last_elem, walking;

    ovr_hdr_decode #(.MAX_LEN(MAX_LEN)) u_dec (
        .word(rd_data), .hdr(dec_hdr), .is_term(dec_term), .len_bad(dec_bad)
    );

    ovr_addr_gen #(.REG_BASE(REG_BASE), .PRM_AW(PRM_AW)) u_agen (
        .hdr(hdr_q), .elem(elem), .reg_addr(gen_reg_addr),
        .bus_addr(gen_bus_addr), .prm_idx(gen_prm_idx)
    );

    ovr_lane_pick u_pick (
        .dbuf(dbuf), .lane(lane), .half_v(pick_half), .byte_v(pick_byte)
    );

    always_comb begin
        unique case (hdr_q.atype)
            AT_HALF, AT_WORD: sel_ready = reg_wr_ready;
            AT_BUS:           sel_ready = bus_wr_ready;
            default:          sel_ready = prm_wr_ready;
        endcase
        fire      = (state == S_WR) && sel_ready;
        last_elem = (elem == hdr_q.len - HDR_LEN_W'(1));
        walking   = (state == S_HDR_RD) || (state == S_HDR) || (state == S_DAT_RD)
                 || (state == S_DAT) || (state == S_WR);
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        stat_nx  = stat_q;
        unique case (state)
            S_IDLE:   if (start) state_nx = S_ARMED;
            S_ARMED: begin
                if (stop_req || abort_req) begin
                    state_nx = S_DONE;
                    stat_nx  = ST_ABORTED;
                end else if (trigger) begin
                    state_nx = S_HDR_RD;
                end
            end
            S_HDR_RD: state_nx = S_HDR;
            S_HDR: begin
                if (dec_term) begin
                    state_nx = S_DONE;
                    stat_nx  = ST_OK;
                end else if (dec_bad) begin
                    state_nx = S_DONE;
                    stat_nx  = ST_PARAM_ERR;
                end else begin
                    state_nx = S_DAT_RD;
                end
            end
            S_DAT_RD: state_nx = S_DAT;
            S_DAT:    state_nx = S_WR;
            S_WR: begin
                if (fire) begin
                    if (last_elem)                         state_nx = S_HDR_RD;
                    else if (lane == last_lane(hdr_q.atype)) state_nx = S_DAT_RD;
                end
            end
            default:  state_nx = S_IDLE;
        endcase
        if (walking && abort_req) begin
            state_nx = S_DONE;
            stat_nx  = ST_ABORTED;
        end
    end

    // state register and datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= S_IDLE;
            stat_q <= ST_OK;
            ptr    <= '0;
            hdr_q  <= '0;
            dbuf   <= '0;
            elem   <= '0;
            lane   <= '0;
        end else begin
            state  <= state_nx;
            stat_q <= stat_nx;
            unique case (state)
                S_IDLE: if (start) ptr <= list_base;
                S_HDR: begin
                    hdr_q <= dec_hdr;
                    elem  <= '0;
                    if (!dec_term && !dec_bad) ptr <= ptr + LIST_AW'(1);
                end
                S_DAT: begin
                    dbuf <= rd_data;
                    lane <= 2'd0;
                    ptr  <= ptr + LIST_AW'(1);
                end
                S_WR: if (fire) begin
                    elem <= elem + HDR_LEN_W'(1);
                    lane <= lane + 2'd1;
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        rd_en        = (state == S_HDR_RD) || (state == S_DAT_RD);
        rd_addr      = ptr;
        reg_wr_valid = (state == S_WR) && (hdr_q.atype == AT_HALF || hdr_q.atype == AT_WORD);
        bus_wr_valid = (state == S_WR) && (hdr_q.atype == AT_BUS);
        prm_wr_valid = (state == S_WR) && (hdr_q.atype == AT_PRM);
        reg_wr_addr  = gen_reg_addr;
        reg_wr_data  = (hdr_q.atype == AT_HALF) ? {16'd0, pick_half} : dbuf;
        bus_wr_sel   = hdr_q.start[7];
        bus_wr_half  = hdr_q.start[6];
        bus_wr_addr  = gen_bus_addr;
        bus_wr_data  = pick_byte;
        prm_wr_idx   = gen_prm_idx;
        prm_wr_data  = pick_byte;
        done         = (state == S_DONE);
        status       = stat_q;
    end
endmodule

// File: rtl/ovr_array_seq_chk.sv
module ovr_array_seq_chk
    import ovr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        abort_req,
    input logic        rd_en,
    input logic        reg_wr_valid,
    input logic        reg_wr_ready,
    input logic [31:0] reg_wr_addr,
    input logic [31:0] reg_wr_data,
    input logic        bus_wr_valid,
    input logic        bus_wr_ready,
    input logic [5:0]  bus_wr_addr,
    input logic [7:0]  bus_wr_data,
    input logic        prm_wr_valid,
    input logic        done,
    input logic [1:0]  status,
    input logic [2:0]  state,
    input logic [1:0]  hdr_type
);
    // R13
    one_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({reg_wr_valid, bus_wr_valid, prm_wr_valid}));

    // R13
    reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid && !reg_wr_ready && !abort_req) |=>
            (reg_wr_valid && $stable(reg_wr_addr) && $stable(reg_wr_data)));

    // R13
    bus_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr_valid && !bus_wr_ready && !abort_req) |=>
            (bus_wr_valid && $stable(bus_wr_addr) && $stable(bus_wr_data)));

    // R3
    half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr_valid && hdr_type == 2'd0) |-> (reg_wr_data[31:16] == 16'd0));

    // R14
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R12
    abort_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_req && state != 3'(S_IDLE) && state != 3'(S_DONE)) |=>
            (done && status == 2'd2));

    // R10
    armed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 3'(S_ARMED)) |-> !(rd_en || reg_wr_valid || bus_wr_valid || prm_wr_valid));
endmodule

bind ovr_array_seq ovr_array_seq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .abort_req(abort_req), .rd_en(rd_en),
    .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
    .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .bus_wr_valid(bus_wr_valid), .bus_wr_ready(bus_wr_ready),
    .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data),
    .prm_wr_valid(prm_wr_valid), .done(done), .status(status),
    .state(state), .hdr_type(hdr_q.atype)
);

// File: tb/ovr_array_seq_bench.sv
module ovr_array_seq_bench;
    localparam int          LIST_AW  = 8;
    localparam int          MAX_LEN  = 40;
    localparam int          PRM_AW   = 6;
    localparam logic [31:0] REG_BASE = 32'h4004_0000;

    typedef struct {
        logic [1:0]  port;
        logic [31:0] addr;
        logic [31:0] data;
    } item_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, trigger = 0, stop_req = 0, abort_req = 0;
    logic [LIST_AW-1:0] list_base = '0;
    logic rd_en; logic [LIST_AW-1:0] rd_addr; logic [31:0] rd_data = '0;
    logic reg_wr_valid, reg_wr_ready; logic [31:0] reg_wr_addr, reg_wr_data;
    logic bus_wr_valid, bus_wr_ready, bus_wr_sel, bus_wr_half;
    logic [5:0] bus_wr_addr; logic [7:0] bus_wr_data;
    logic prm_wr_valid, prm_wr_ready; logic [PRM_AW-1:0] prm_wr_idx; logic [7:0] prm_wr_data;
    logic done; logic [1:0] status;

    logic [31:0] mem [0:255];
    item_t exp_q[$];
    int checks = 0, errors = 0, rd_cnt = 0, hs_cnt = 0, cyc = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic gate_ready = 1'b1;

    always #4 clk = ~clk;

    ovr_array_seq #(.LIST_AW(LIST_AW), .MAX_LEN(MAX_LEN), .PRM_AW(PRM_AW), .REG_BASE(REG_BASE))
    u_ovr_array_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .list_base(list_base), .trigger(trigger),
        .stop_req(stop_req), .abort_req(abort_req), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .reg_wr_valid(reg_wr_valid), .reg_wr_ready(reg_wr_ready),
        .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data), .bus_wr_valid(bus_wr_valid),
        .bus_wr_ready(bus_wr_ready), .bus_wr_sel(bus_wr_sel), .bus_wr_half(bus_wr_half),
        .bus_wr_addr(bus_wr_addr), .bus_wr_data(bus_wr_data), .prm_wr_valid(prm_wr_valid),
        .prm_wr_ready(prm_wr_ready), .prm_wr_idx(prm_wr_idx), .prm_wr_data(prm_wr_data),
        .done(done), .status(status)
    );

    always @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    end
    assign reg_wr_ready = gate_ready & lfsr[0];
    assign bus_wr_ready = gate_ready & lfsr[3];
    assign prm_wr_ready = gate_ready & lfsr[7];

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // scoreboard monitor and handshake-hold observer (R13)
    logic        prev_stall = 0, prev_abort = 0;
    logic [31:0] prev_a = 0, prev_d = 0;
    always @(negedge clk) begin
        item_t got, e;
        logic any_v;
        any_v = reg_wr_valid | bus_wr_valid | prm_wr_valid;
        if (rst_n) begin
            if (rd_en) rd_cnt++;
            if (any_v) check($countones({reg_wr_valid, bus_wr_valid, prm_wr_valid}) == 1,
                             "R13 one valid", 32'(reg_wr_valid + bus_wr_valid + prm_wr_valid), 1);
            got.port = reg_wr_valid ? 2'd0 : bus_wr_valid ? 2'd1 : 2'd2;
            got.addr = reg_wr_valid ? reg_wr_addr :
                       bus_wr_valid ? {24'd0, bus_wr_sel, bus_wr_half, bus_wr_addr} : 32'(prm_wr_idx);
            got.data = reg_wr_valid ? reg_wr_data : bus_wr_valid ? 32'(bus_wr_data) : 32'(prm_wr_data);
            if (prev_stall && !prev_abort)
                check(any_v && got.addr == prev_a && got.data == prev_d, "R13 hold", got.data, prev_d);
            if ((reg_wr_valid && reg_wr_ready) || (bus_wr_valid && bus_wr_ready) ||
                (prm_wr_valid && prm_wr_ready)) begin
                hs_cnt++;
                if (exp_q.size() == 0) check(0, "R3-write unexpected", got.addr, 0);
                else begin
                    e = exp_q.pop_front();
                    check(e.port == got.port && e.addr == got.addr && e.data == got.data,
                          "R3 R5 R6 R7 write", got.data, e.data);
                    if (e.addr != got.addr) $display("FAIL R3 R6 R7 address actual=%h expected=%h", got.addr, e.addr);
                end
                prev_stall = 0;
            end else begin
                prev_stall = any_v;
            end
            prev_a = got.addr; prev_d = got.data; prev_abort = abort_req;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic [31:0] hdrw(input logic [1:0] t, input int len, input logic [7:0] s);
        return {t, 14'(len), 8'd0, s};
    endfunction

    // independent model of the list walk: pushes expected writes, returns final status
    task automatic model(input int base, output logic [1:0] st);
        int p = base;
        forever begin
            logic [31:0] w;
            logic [1:0] t; int len, s, epw;
            w = mem[p];
            if (w == 0) begin st = 2'd0; return; end
            t = w[31:30]; len = int'(w[29:16]); s = int'(w[7:0]);
            if (len == 0 || len > MAX_LEN) begin st = 2'd1; return; end
            p++;
            epw = (t == 2'd0) ? 2 : (t == 2'd1) ? 1 : 4;
            for (int k = 0; k < len; k++) begin
                item_t it;
                logic [31:0] dw;
                dw = mem[p + k / epw];
                unique case (t)
                    2'd0: begin it.port = 0; it.addr = REG_BASE + 32'(4*s) + 32'(4*k);
                                it.data = (dw >> (16*(k%2))) & 32'hFFFF; end
                    2'd1: begin it.port = 0; it.addr = REG_BASE + 32'(4*s) + 32'(4*k); it.data = dw; end
                    2'd2: begin it.port = 1;
                                it.addr = {24'd0, 1'(s >> 7), 1'(s >> 6),
                                           6'((s % 64) + (((s >> 6) % 2 == 1) ? k : 2*k))};
                                it.data = (dw >> (8*(k%4))) & 32'hFF; end
                    default: begin it.port = 2; it.addr = 32'(((s / 4) + k) % 64);
                                it.data = (dw >> (8*(k%4))) & 32'hFF; end
                endcase
                exp_q.push_back(it);
            end
            p += (len + epw - 1) / epw;
        end
    endtask

    task automatic arm(input int base);
        @(negedge clk); start = 1; list_base = LIST_AW'(base);
        @(negedge clk); start = 0;
    endtask

    task automatic pulse_trig;
        @(negedge clk); trigger = 1;
        @(negedge clk); trigger = 0;
    endtask

    task automatic wait_done(input logic [1:0] exp_st, input string req);
        int n = 0;
        while (!done && n < 3000) begin @(negedge clk); n++; end
        check(done == 1'b1, req, 32'(done), 1);
        check(status == exp_st, req, 32'(status), 32'(exp_st));
        @(negedge clk);
        check(done == 1'b0, "R14 done one cycle", 32'(done), 0);
    endtask

    task automatic run_full(input int base, input string req, input bit stop_mid);
        logic [1:0] st;
        model(base, st);
        arm(base);
        pulse_trig();
        if (stop_mid) begin
            repeat (6) @(negedge clk);
            stop_req = 1; @(negedge clk); stop_req = 0;
        end
        wait_done(st, req);
        check(exp_q.size() == 0, {req, " all writes seen"}, 32'(exp_q.size()), 0);
    endtask

    initial begin
        logic [1:0] st;
        for (int i = 0; i < 256; i++) mem[i] = 32'd0;
        // list A: half array odd length (pad word carries junk), word array, terminator
        mem[0] = hdrw(2'd0, 3, 8'h10); mem[1] = 32'hBBBB_AAAA; mem[2] = 32'hDEAD_CCCC;
        mem[3] = hdrw(2'd1, 2, 8'h02); mem[4] = 32'h1234_5678; mem[5] = 32'h9ABC_DEF0;
        mem[6] = 32'd0;
        // list B: bus half with wrap, bus full on instance 1 with wrap, param bytes
        mem[16] = hdrw(2'd2, 5, 8'h7E); mem[17] = 32'h4433_2211; mem[18] = 32'hFF88_7766;
        mem[19] = hdrw(2'd2, 3, 8'hBC); mem[20] = 32'hEECC_BBAA;
        mem[21] = hdrw(2'd3, 6, 8'h14); mem[22] = 32'h0D0C_0B0A; mem[23] = 32'hAAAA_0F0E;
        mem[24] = 32'd0;
        // list C: valid word array then zero length
        mem[48] = hdrw(2'd1, 1, 8'h00); mem[49] = 32'hCAFE_F00D; mem[50] = hdrw(2'd0, 0, 8'h05);
        // list D: length above MAX_LEN
        mem[56] = hdrw(2'd3, 50, 8'h00); mem[57] = 32'h1111_1111;

        repeat (3) @(negedge clk);
        // R1 reset state
        check(!done && !rd_en, "R1 reset done/rd_en", {30'd0, done, rd_en}, 0);
        check(!(reg_wr_valid | bus_wr_valid | prm_wr_valid), "R1 reset valids",
              {29'd0, reg_wr_valid, bus_wr_valid, prm_wr_valid}, 0);
        rst_n = 1;
        @(negedge clk);

        run_full(0,  "R2 R3 R4 R5 list A", 0);
        run_full(16, "R6 R7 R8 list B", 0);
        run_full(48, "R9 zero length", 0);
        run_full(56, "R9 length over max", 0);

        // R10: stop and trigger in the same cycle while armed
        rd_cnt = 0; hs_cnt = 0;
        arm(0);
        @(negedge clk); stop_req = 1; trigger = 1;
        @(negedge clk); stop_req = 0; trigger = 0;
        wait_done(2'd2, "R10 stop with trigger");
        check(rd_cnt == 0 && hs_cnt == 0, "R10 no reads or writes", 32'(rd_cnt + hs_cnt), 0);
        // R10: abort while armed
        arm(16);
        @(negedge clk); abort_req = 1;
        @(negedge clk); abort_req = 0;
        wait_done(2'd2, "R10 abort armed");
        check(rd_cnt == 0 && hs_cnt == 0, "R10 no reads after abort", 32'(rd_cnt + hs_cnt), 0);

        // R11: stop after trigger is ignored
        run_full(16, "R11 stop after trigger", 1);

        // R12: abort coinciding with an accepted register write
        model(0, st);
        hs_cnt = 0;
        arm(0);
        pulse_trig();
        while (!(reg_wr_valid && reg_wr_ready && hs_cnt >= 1)) @(negedge clk);
        abort_req = 1;
        @(negedge clk); abort_req = 0;
        check(done && status == 2'd2, "R12 abort ends next cycle", {30'd0, status}, 2);
        check(hs_cnt == 2 && exp_q.size() == 3, "R12 coincident write counted", 32'(hs_cnt), 2);
        exp_q.delete();
        hs_cnt = 0;
        repeat (8) @(negedge clk);
        check(hs_cnt == 0 && !reg_wr_valid, "R12 no writes after abort", 32'(hs_cnt), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule